// File: doc/BRIEF.md
# Sequence-Preserving Cell Dispatcher

The dispatcher is a staging controller that sits between a routing stage and a concentration stage of a cell switch. In each cell slot it takes up to `LANES` fixed-size cells on a multi-lane ingress port and keeps them in arrival order in an internal queue. Downstream it feeds `LANES` one-cell buffers. Whenever one of these buffers reports empty and the queue holds a cell, the oldest cell moves into that buffer. Each moved cell carries a sequence tag.

Each controller also drives a live port priority that is common to all of its buffered cells. A concentrator compares the pair {port priority, sequence tag} for every cell it sees, and a smaller value wins. `NUM_CTRL` controllers share one concentrator. The port priority of each controller steps round-robin at every slot boundary. A controller restarts its sequence tags from zero only after a slot in which it held the top port priority. In such a slot all of its buffered cells are cleared, so each controller's cells leave the concentrator in the order they arrived.

The queue is tracked by a small state machine with three states. `FQ_EMPTY` means no cells are stored and nothing is dispatched. `FQ_OPEN` means cells are stored and there is room for a full set of lanes. `FQ_BLOCKED` means fewer than `LANES` free entries remain, so ingress is held off. The transitions are EMPTY→OPEN on the first push, OPEN→EMPTY when the last cell leaves, OPEN→BLOCKED when the free space drops below `LANES`, BLOCKED→OPEN when enough room returns, and BLOCKED→EMPTY when a full drain leaves the queue empty. The state is recomputed from the next fill level on every clock.

Top module: `isc_dispatcher`

## Requirements
- R1: After reset, `out_valid` is all zero, `in_ready` is 1 and `port_pri` equals the parameter `CTRL_IDX`.
- R2: When `in_ready` is 1, every lane with `in_valid` set is stored, in ascending lane order. Cells leave the queue strictly in the order they were stored.
- R3: `in_ready` is 0 exactly when fewer than `LANES` queue entries are free. Cells offered while it is 0 are not stored. No accepted cell is ever lost.
- R4: `out_valid[i]` is set only when `buf_empty[i]` is 1. In each cycle the number of dispatches equals min(stored cells, empty buffers). The lowest-indexed empty buffers are served first, and the oldest cell goes to the lowest index.
- R5: The k-th dispatch of a cycle (k counted from 0 in ascending lane order) carries a sequence tag of base+k. The base then advances by the number of cells dispatched in that cycle.
- R6: `port_pri` changes only in the cycle after a `slot_start` pulse. It then takes the old value minus 1, and 0 wraps to `NUM_CTRL-1`.
- R7: In a `slot_start` cycle where `port_pri` is 0, the base is 0 for that cycle's dispatches and for the dispatches that follow.
- R8: With `NUM_CTRL` controllers feeding a concentrator that clears the `LANES` lowest {port_pri, tag} pairs at each slot end, each controller's cells are delivered in arrival order.
- R9: The sequence tag and its base saturate at `SEQ_LEVELS-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_start | input | 1 | One-cycle pulse marking the first cycle of a cell slot |
| in_valid | input | LANES | Per-lane ingress cell present |
| in_cells | input | LANES*CELL_W | Ingress cells, lane i at bits [i*CELL_W +: CELL_W] |
| in_ready | output | 1 | Queue can take a full set of lanes this cycle |
| buf_empty | input | LANES | Downstream one-cell buffer i is empty |
| out_valid | output | LANES | Buffer i is loaded at this clock edge |
| out_cells | output | LANES*CELL_W | Cell for buffer i |
| out_seq | output | LANES*SEQ_W | Sequence tag for buffer i |
| port_pri | output | PRI_W | Live port priority of all cells held by this controller |

## Verification
The bench first fills the queue while every buffer is occupied, to drive it into the blocked state. It then drains four cells per cycle, so the tag runs to the saturation value, and fires a slot boundary while the controller holds priority 0. A design that let a cell in while blocked would break the arrival order. A design that wrapped the counter instead of saturating it, or that missed the restart, would show wrong tags. Three controllers are then run against a concentrator model, first with the fixed 4/1/0 cells-per-slot load and then with random loads. Rotating the priority the wrong way, restarting the tag at the wrong slot, or filling buffers out of index order would reorder the delivered cells.

// File: rtl/isc_pkg.sv
package isc_pkg;

    typedef enum logic [1:0] {
        FQ_EMPTY   = 2'd0,
        FQ_OPEN    = 2'd1,
        FQ_BLOCKED = 2'd2
    } fq_state_e;

    // Sum of two values clipped at a ceiling.
    function automatic int unsigned sat_add(input int unsigned a,
                                            input int unsigned b,
                                            input int unsigned ceil_v);
        int unsigned s;
        s = a + b;
        return (s > ceil_v) ? ceil_v : s;
    endfunction

endpackage

// File: rtl/isc_cell_fifo.sv
module isc_cell_fifo
    import isc_pkg::*;
#(
    parameter int LANES  = 4,
    parameter int CELL_W = 16,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int NUM_W = $clog2(LANES + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES-1:0]        push_valid,
    input  logic [LANES*CELL_W-1:0] push_cells,
    input  logic [NUM_W-1:0]        pop_num,
    output logic [LANES*CELL_W-1:0] head_cells,
    output logic [CNT_W-1:0]        fill,
    output logic                    accept
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [CELL_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  fill_q, fill_d;
    logic [NUM_W-1:0]  push_rank [LANES];
    logic [NUM_W-1:0]  push_num;
    fq_state_e         state_q, state_d;

    function automatic logic [PTR_W-1:0] wrap(input logic [PTR_W-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s = s - DEPTH;
        return PTR_W'(s);
    endfunction

    function automatic fq_state_e classify(input logic [CNT_W-1:0] f);
        if (f == '0)                         return FQ_EMPTY;
        else if ((DEPTH - int'(f)) < LANES)  return FQ_BLOCKED;
        else                                 return FQ_OPEN;
    endfunction

    // Compact the valid lanes: each valid lane gets the count of valid lanes below it.
    always_comb begin
        int acc;
        acc = 0;
        for (int i = 0; i < LANES; i++) begin
            push_rank[i] = NUM_W'(acc);
            if (push_valid[i]) acc = acc + 1;
        end
        push_num = accept ? NUM_W'(acc) : '0;
    end

    assign fill_d = fill_q + CNT_W'(push_num) - CNT_W'(pop_num);

    // Next-state process
    always_comb begin
        unique case (state_q)
            FQ_EMPTY:   state_d = (push_num != '0) ? classify(fill_d) : FQ_EMPTY;
            FQ_OPEN:    state_d = classify(fill_d);
            FQ_BLOCKED: state_d = classify(fill_d);
            default:    state_d = FQ_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FQ_EMPTY;
        else        state_q <= state_d;
    end

    // Output process
    always_comb begin
        unique case (state_q)
            FQ_EMPTY:   accept = 1'b1;
            FQ_OPEN:    accept = 1'b1;
            FQ_BLOCKED: accept = 1'b0;
            default:    accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
        end else begin
            wr_q   <= wrap(wr_q, int'(push_num));
            rd_q   <= wrap(rd_q, int'(pop_num));
            fill_q <= fill_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (accept && push_valid[i])
                mem[wrap(wr_q, int'(push_rank[i]))] <= push_cells[i*CELL_W +: CELL_W];
        end
    end

    always_comb begin
        for (int k = 0; k < LANES; k++)
            head_cells[k*CELL_W +: CELL_W] = mem[wrap(rd_q, k)];
    end

    assign fill = fill_q;

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_q <= CNT_W'(DEPTH))
        else $error("queue fill above depth");

    assert_pop_within_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        CNT_W'(pop_num) <= fill_q)
        else $error("more cells popped than stored");

    assert_blocked_means_tight_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FQ_BLOCKED) |-> ((DEPTH - int'(fill_q)) < LANES))
        else $error("blocked with room for a full lane set");

endmodule

// File: rtl/isc_lane_assign.sv
module isc_lane_assign #(
    parameter int LANES = 4,
    parameter int CNT_W = 5,
    localparam int RANK_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int NUM_W  = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]        buf_empty,
    input  logic [CNT_W-1:0]        fill,
    output logic [LANES-1:0]        lane_go,
    output logic [LANES*RANK_W-1:0] lane_rank,
    output logic [NUM_W-1:0]        go_num
);

    // Ascending scan: empty buffer i takes the oldest cell not yet handed out.
    always_comb begin
        int seen;
        seen = 0;
        for (int i = 0; i < LANES; i++) begin
            lane_rank[i*RANK_W +: RANK_W] = RANK_W'((seen < LANES) ? seen : LANES - 1);
            lane_go[i] = buf_empty[i] && (seen < int'(fill));
            if (lane_go[i]) seen = seen + 1;
        end
        go_num = NUM_W'(seen);
    end

endmodule

// File: rtl/isc_tag_gen.sv
module isc_tag_gen
    import isc_pkg::*;
#(
    parameter int NUM_CTRL   = 3,
    parameter int LANES      = 4,
    parameter int SEQ_LEVELS = 12,
    parameter int CTRL_IDX   = 0,
    localparam int PRI_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
    localparam int SEQ_W = (SEQ_LEVELS > 1) ? $clog2(SEQ_LEVELS) : 1,
    localparam int NUM_W = $clog2(LANES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_start,
    input  logic [NUM_W-1:0] go_num,
    output logic [PRI_W-1:0] port_pri,
    output logic [SEQ_W-1:0] seq_base
);

    localparam int SEQ_TOP = SEQ_LEVELS - 1;

    logic [PRI_W-1:0] pri_q, pri_d;
    logic [SEQ_W-1:0] seq_q, seq_d;
    logic             restart;

    // The slot that just ended had top priority: every buffered cell was cleared.
    assign restart  = slot_start && (pri_q == '0);
    assign seq_base = restart ? '0 : seq_q;
    assign seq_d    = SEQ_W'(sat_add(int'(seq_base), int'(go_num), SEQ_TOP));

    always_comb begin
        pri_d = pri_q;
        if (slot_start)
            pri_d = (pri_q == '0) ? PRI_W'(NUM_CTRL - 1) : pri_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= PRI_W'(CTRL_IDX % NUM_CTRL);
            seq_q <= '0;
        end else begin
            pri_q <= pri_d;
            seq_q <= seq_d;
        end
    end

    assign port_pri = pri_q;

    assert_pri_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pri_q) < NUM_CTRL)
        else $error("port priority out of range");

    assert_pri_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> $stable(pri_q))
        else $error("port priority moved without a slot boundary");

    assert_seq_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(seq_q) <= SEQ_TOP)
        else $error("sequence base above ceiling");

    assert_seq_nondecreasing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_start |=> (seq_q >= $past(seq_q)))
        else $error("sequence base went backwards inside a slot");

endmodule

// File: rtl/isc_dispatcher.sv
module isc_dispatcher
    import isc_pkg::*;
#(
    parameter int NUM_CTRL   = 3,
    parameter int LANES      = 4,
    parameter int CELL_W     = 16,
    parameter int FIFO_DEPTH = 16,
    parameter int SEQ_LEVELS = NUM_CTRL * LANES,
    parameter int CTRL_IDX   = 0,
    localparam int PRI_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1,
    localparam int SEQ_W = (SEQ_LEVELS > 1) ? $clog2(SEQ_LEVELS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    slot_start,
    input  logic [LANES-1:0]        in_valid,
    input  logic [LANES*CELL_W-1:0] in_cells,
    output logic                    in_ready,
    input  logic [LANES-1:0]        buf_empty,
    output logic [LANES-1:0]        out_valid,
    output logic [LANES*CELL_W-1:0] out_cells,
    output logic [LANES*SEQ_W-1:0]  out_seq,
    output logic [PRI_W-1:0]        port_pri
);

    localparam int CNT_W  = $clog2(FIFO_DEPTH + 1);
    localparam int NUM_W  = $clog2(LANES + 1);
    localparam int RANK_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [LANES*CELL_W-1:0] head_cells;
    logic [CNT_W-1:0]        fill;
    logic [LANES-1:0]        lane_go;
    logic [LANES*RANK_W-1:0] lane_rank;
    logic [NUM_W-1:0]        go_num;
    logic [SEQ_W-1:0]        seq_base;

    isc_cell_fifo #(
        .LANES (LANES),
        .CELL_W(CELL_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(in_valid),
        .push_cells(in_cells),
        .pop_num   (go_num),
        .head_cells(head_cells),
        .fill      (fill),
        .accept    (in_ready)
    );

    isc_lane_assign #(
        .LANES(LANES),
        .CNT_W(CNT_W)
    ) u_assign (
        .buf_empty(buf_empty),
        .fill     (fill),
        .lane_go  (lane_go),
        .lane_rank(lane_rank),
        .go_num   (go_num)
    );

    isc_tag_gen #(
        .NUM_CTRL  (NUM_CTRL),
        .LANES     (LANES),
        .SEQ_LEVELS(SEQ_LEVELS),
        .CTRL_IDX  (CTRL_IDX)
    ) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_start(slot_start),
        .go_num    (go_num),
        .port_pri  (port_pri),
        .seq_base  (seq_base)
    );

    // Per-lane steering of the queue head and tag numbering.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [RANK_W-1:0] rank;
        assign rank = lane_rank[g*RANK_W +: RANK_W];
        assign out_valid[g] = lane_go[g];
        assign out_cells[g*CELL_W +: CELL_W] =
            lane_go[g] ? head_cells[int'(rank)*CELL_W +: CELL_W] : '0;
        assign out_seq[g*SEQ_W +: SEQ_W] =
            lane_go[g] ? SEQ_W'(sat_add(int'(seq_base), int'(rank), SEQ_LEVELS - 1)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < LANES; i++) begin
                assert_go_only_on_empty_R4: assert (!(out_valid[i] && !buf_empty[i]))
                    else $error("dispatch into occupied buffer %0d", i);
                for (int j = i + 1; j < LANES; j++) begin
                    if (out_valid[i] && out_valid[j]) begin
                        assert_seq_ascending_R5: assert (out_seq[i*SEQ_W +: SEQ_W] <= out_seq[j*SEQ_W +: SEQ_W])
                            else $error("tags not ascending over lanes %0d,%0d", i, j);
                    end
                end
            end
        end
    end

    assert_blocked_no_growth_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (fill <= $past(fill)))
        else $error("queue grew while ingress was held off");

endmodule

// File: tb/isc_dispatcher_tb.sv
module isc_dispatcher_tb;

    localparam int J   = 3;
    localparam int M   = 4;
    localparam int W   = 16;
    localparam int D   = 16;
    localparam int LV  = J * M;
    localparam int PPW = 2;
    localparam int SQW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic slot_start;
    logic [M-1:0]     inv    [J];
    logic [M*W-1:0]   incell [J];
    logic             rdy    [J];
    logic [M-1:0]     bemp   [J];
    logic [M-1:0]     ov     [J];
    logic [M*W-1:0]   oc     [J];
    logic [M*SQW-1:0] os     [J];
    logic [PPW-1:0]   pp     [J];

    isc_dispatcher #(.NUM_CTRL(J), .LANES(M), .CELL_W(W), .FIFO_DEPTH(D), .CTRL_IDX(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .in_valid(inv[0]), .in_cells(incell[0]),
        .in_ready(rdy[0]), .buf_empty(bemp[0]), .out_valid(ov[0]), .out_cells(oc[0]),
        .out_seq(os[0]), .port_pri(pp[0]));
    isc_dispatcher #(.NUM_CTRL(J), .LANES(M), .CELL_W(W), .FIFO_DEPTH(D), .CTRL_IDX(1)) u_ctl1 (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .in_valid(inv[1]), .in_cells(incell[1]),
        .in_ready(rdy[1]), .buf_empty(bemp[1]), .out_valid(ov[1]), .out_cells(oc[1]),
        .out_seq(os[1]), .port_pri(pp[1]));
    isc_dispatcher #(.NUM_CTRL(J), .LANES(M), .CELL_W(W), .FIFO_DEPTH(D), .CTRL_IDX(2)) u_ctl2 (
        .clk(clk), .rst_n(rst_n), .slot_start(slot_start), .in_valid(inv[2]), .in_cells(incell[2]),
        .in_ready(rdy[2]), .buf_empty(bemp[2]), .out_valid(ov[2]), .out_cells(oc[2]),
        .out_seq(os[2]), .port_pri(pp[2]));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [W-1:0] mfifo [J][64];
    int  mhead [J];
    int  mtail [J];
    int  mseq  [J];
    int  mpp   [J];
    bit  bufv  [J][M];
    logic [W-1:0] bufc [J][M];
    int  bufs  [J][M];
    int  pend  [J];
    int  acc_next [J];
    int  dnext [J];
    int  noff  [J];
    int  delivered = 0;

    function automatic int f_next_pp(input int p);
        return (p == 0) ? J - 1 : p - 1;
    endfunction

    function automatic int f_sat(input int v);
        return (v > LV - 1) ? LV - 1 : v;
    endfunction

    function automatic logic [W-1:0] f_cell(input int c, input int serial);
        return W'((c << 14) | (serial & 16'h3fff));
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < J; c++) begin
            mhead[c] = 0; mtail[c] = 0; mseq[c] = 0; mpp[c] = c;
            pend[c] = 0; acc_next[c] = 0; dnext[c] = 0; noff[c] = 0;
            for (int i = 0; i < M; i++) begin
                bufv[c][i] = 0; bufc[c][i] = '0; bufs[c][i] = 0;
            end
        end
        delivered = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        slot_start = 1'b0;
        for (int c = 0; c < J; c++) begin
            inv[c] = '0; incell[c] = '0; bemp[c] = '1;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #2;
        for (int c = 0; c < J; c++) begin
            chk("R1", "out_valid after reset", int'(ov[c]), 0);
            chk("R1", "in_ready after reset", int'(rdy[c]), 1);
            chk("R1", "port_pri after reset", int'(pp[c]), c);
        end
    endtask

    // Concentrator model: clear the M buffered cells with the smallest {port_pri, tag}.
    task automatic concentrate();
        for (int c = 0; c < J; c++)
            chk("R6", "port_pri at slot end", int'(pp[c]), mpp[c]);
        for (int pick = 0; pick < M; pick++) begin
            int bc, bi, bk;
            bc = -1; bi = 0; bk = 0;
            for (int c = 0; c < J; c++) begin
                for (int i = 0; i < M; i++) begin
                    if (bufv[c][i]) begin
                        int key;
                        key = mpp[c] * 1000 + bufs[c][i];
                        if (bc < 0 || key < bk) begin
                            bc = c; bi = i; bk = key;
                        end
                    end
                end
            end
            if (bc >= 0) begin
                chk("R8", "delivery order", int'(bufc[bc][bi]), int'(f_cell(bc, dnext[bc])));
                dnext[bc]++;
                bufv[bc][bi] = 0;
                delivered++;
            end
        end
    endtask

    task automatic step(input bit ss, input bit drain, input bit conc);
        @(negedge clk);
        if (conc) concentrate();
        slot_start = ss;
        for (int c = 0; c < J; c++) begin
            logic [M-1:0] mask;
            int nset, k;
            noff[c] = (pend[c] > M) ? M : pend[c];
            mask = '1;
            nset = M;
            while (nset > noff[c]) begin
                int idx;
                idx = int'($urandom_range(0, M - 1));
                if (mask[idx]) begin
                    mask[idx] = 1'b0;
                    nset--;
                end
            end
            inv[c] = mask;
            k = 0;
            for (int i = 0; i < M; i++) begin
                if (mask[i]) begin
                    incell[c][i*W +: W] = f_cell(c, acc_next[c] + k);
                    k++;
                end else begin
                    incell[c][i*W +: W] = '0;
                end
                bemp[c][i] = !bufv[c][i];
            end
        end
        #2;
        for (int c = 0; c < J; c++) begin
            int cnt, base, k;
            bit erdy, rs;
            cnt  = mtail[c] - mhead[c];
            erdy = (D - cnt) >= M;
            rs   = ss && (mpp[c] == 0);
            base = rs ? 0 : mseq[c];
            chk("R3", "in_ready", int'(rdy[c]), int'(erdy));
            chk("R6", "port_pri", int'(pp[c]), mpp[c]);
            k = 0;
            for (int i = 0; i < M; i++) begin
                if (bemp[c][i] && k < cnt) begin
                    string treq;
                    treq = rs ? "R7" : ((base + k > LV - 1) ? "R9" : "R5");
                    chk("R4", "out_valid on empty buffer", int'(ov[c][i]), 1);
                    chk("R2", "dispatched cell", int'(oc[c][i*W +: W]), int'(mfifo[c][(mhead[c] + k) % 64]));
                    chk(treq, "sequence tag", int'(os[c][i*SQW +: SQW]), f_sat(base + k));
                    bufv[c][i] = 1;
                    bufc[c][i] = mfifo[c][(mhead[c] + k) % 64];
                    bufs[c][i] = f_sat(base + k);
                    k++;
                end else begin
                    chk("R4", "no dispatch on this lane", int'(ov[c][i]), 0);
                end
            end
            mhead[c] += k;
            mseq[c] = f_sat(base + k);
            if (ss) mpp[c] = f_next_pp(mpp[c]);
            if (erdy) begin
                for (int j = 0; j < noff[c]; j++) begin
                    mfifo[c][mtail[c] % 64] = f_cell(c, acc_next[c] + j);
                    mtail[c]++;
                end
                acc_next[c] += noff[c];
                pend[c] -= noff[c];
            end
            if (drain)
                for (int i = 0; i < M; i++) bufv[c][i] = 0;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog expired actual=%0d expected=%0d", delivered, -1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // Directed: all buffers of controller 0 held full, queue fills until blocked (R3).
        for (int i = 0; i < M; i++) begin
            bufv[0][i] = 1; bufs[0][i] = 0; bufc[0][i] = '0;
        end
        pend[0] = 20;
        repeat (6) step(1'b0, 1'b0, 1'b0);
        chk("R3", "cells held back while blocked", pend[0], 4);

        // Drain four per cycle: tags climb to the ceiling (R9), then a restart (R7).
        for (int i = 0; i < M; i++) bufv[0][i] = 0;
        repeat (4) step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        repeat (4) step(1'b0, 1'b1, 1'b0);
        chk("R2", "all directed cells left the queue", mtail[0] - mhead[0], 0);

        // System run with the fixed 4/1/0 load (R8).
        do_reset();
        for (int s = 0; s < 30; s++) begin
            pend[0] += 4;
            pend[1] += 1;
            step(1'b1, 1'b0, 1'b1);
            repeat (4) step(1'b0, 1'b0, 1'b0);
        end

        // Random load per slot (R8).
        for (int s = 0; s < 40; s++) begin
            for (int c = 0; c < J; c++) pend[c] += int'($urandom_range(0, 3));
            step(1'b1, 1'b0, 1'b1);
            repeat (3) step(1'b0, 1'b0, 1'b0);
        end
        chk("R8", "cells delivered in system run", int'(delivered > 100), 1);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule